// File: doc/BRIEF.md
# Serial-Programmed Pulse Countdown Generator

This block sits behind a mode-0 serial peripheral link driven by a host microcontroller. The host writes framed commands over the link. A position frame sets a pulse quantity for each of three axes. A rate frame sets a 24-bit frequency word. The block emits pulses on a single output at the programmed rate and decrements the first axis's remaining quantity once per pulse. The other two axis quantities are held on output ports for neighbouring logic.

Every transaction also returns data to the host. The first four bytes shifted back are a copy of the live remaining count, most significant byte first. That copy is taken in one clock cycle when the select line goes active, so a countdown that is in progress cannot mix bytes from two different counts. The serial clock, data and select inputs are oversampled by the system clock through two-flop synchronisers. The serial clock therefore has to be several times slower than the system clock.

Top module: `spi_pulse_gen`

## Requirements
- R1: After reset, `pulse_out`, `load_axes`, `load_rate` and `spi_miso` are 0, `y_qty` and `z_qty` are 0, and the remaining count and the frequency word are 0.
- R2: A frame whose first byte is 0x01 and that holds at least 13 complete bytes loads three 32-bit quantities from bytes 1–4, 5–8 and 9–12, big-endian. The first quantity becomes the remaining count, and the others appear on `y_qty` and `z_qty`. `load_axes` is high for exactly one cycle, visible after the third rising clock edge following `spi_cs_n` going high.
- R3: A frame whose first byte is 0x02 and that holds at least 4 complete bytes loads the frequency word from bytes 1–3, most significant byte first. `load_rate` pulses for one cycle with the same timing as in R2, and the counting step taken on that same edge still uses the old frequency word.
- R4: A frame with any other first byte, or with fewer complete bytes than its command needs, raises no strobe. It leaves the remaining count, the frequency word, `y_qty` and `z_qty` unchanged.
- R5: On each clock edge where both the frequency word and the remaining count are nonzero, a 24-bit phase accumulator adds the frequency word. A carry out makes `pulse_out` high for the next cycle and lowers the remaining count by one. If the frequency word or the remaining count is zero, no pulse is produced.
- R6: Every transaction returns the 32-bit remaining count as its first 32 bits on `spi_miso`, bit 31 first. The value is the count as it stood after the second rising clock edge following `spi_cs_n` going low, and it is captured on the third.
- R7: `spi_miso` holds bit 31 of the snapshot before the first serial clock rise. It advances one bit after each serial clock fall and shows 0 once all 32 bits have been sent.
- R8: A position load sets the phase accumulator to zero, so the first pulse after a load arrives a whole number of periods after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host, idle low |
| spi_mosi | input | 1 | Serial data from host, sampled on serial clock rise |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_miso | output | 1 | Serial data to host, changes after serial clock fall |
| pulse_out | output | 1 | One-cycle pulse per counted step |
| load_axes | output | 1 | One-cycle strobe on an accepted position frame |
| load_rate | output | 1 | One-cycle strobe on an accepted rate frame |
| y_qty | output | 32 | Second axis quantity |
| z_qty | output | 32 | Third axis quantity |

## Verification
The strobes and register updates from a frame are due three clock edges after `spi_cs_n` rises. The readback snapshot reflects the count two edges after `spi_cs_n` falls. A pulse appears one cycle after the accumulator edge that carried. The bench drives every input one nanosecond after a falling clock edge and samples on falling edges. A behavioural model steps the count and accumulator on each falling edge. At a fixed number of falling edges after each select change, the model compares the strobes with what the frame should produce, and it records the snapshot it expects. The pulse output and the held quantities are compared on every cycle.

// File: rtl/spi_pg_pkg.sv
package spi_pg_pkg;

  localparam logic [7:0] OP_AXES = 8'h01;
  localparam logic [7:0] OP_RATE = 8'h02;

  function automatic int unsigned bytes_for(input int unsigned bits);
    return (bits + 7) / 8;
  endfunction

  function automatic int unsigned axes_frame_len(input int unsigned qty_bits);
    return 1 + 3 * bytes_for(qty_bits);
  endfunction

  function automatic int unsigned rate_frame_len(input int unsigned freq_bits);
    return 1 + bytes_for(freq_bits);
  endfunction

endpackage

// File: rtl/spi_pg_sync.sv
module spi_pg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_pin,
  input  logic mosi_pin,
  input  logic csn_pin,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s,
  output logic selected,
  output logic frame_start,
  output logic frame_end
);

  logic [STAGES-1:0] sck_chain;
  logic [STAGES-1:0] mosi_chain;
  logic [STAGES-1:0] csn_chain;
  logic              sck_prev;
  logic              csn_prev;
  logic              sck_s;
  logic              csn_s;

  assign sck_s = sck_chain[STAGES-1];
  assign csn_s = csn_chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_chain  <= '0;
      mosi_chain <= '0;
      csn_chain  <= '1;
      sck_prev   <= 1'b0;
      csn_prev   <= 1'b1;
    end else begin
      sck_chain  <= {sck_chain[STAGES-2:0], sck_pin};
      mosi_chain <= {mosi_chain[STAGES-2:0], mosi_pin};
      csn_chain  <= {csn_chain[STAGES-2:0], csn_pin};
      sck_prev   <= sck_s;
      csn_prev   <= csn_s;
    end
  end

  assign mosi_s      = mosi_chain[STAGES-1];
  assign selected    = ~csn_s;
  assign sck_rise    = sck_s & ~sck_prev;
  assign sck_fall    = ~sck_s & sck_prev;
  assign frame_start = ~csn_s & csn_prev;
  assign frame_end   = csn_s & ~csn_prev;

endmodule

// File: rtl/spi_pg_rx.sv
module spi_pg_rx #(
  parameter int MAXB = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       rise_i,
  input  logic                       mosi_i,
  output logic [MAXB-1:0][7:0]       bytes_o,
  output logic [$clog2(MAXB+1)-1:0]  count_o
);

  localparam int CW = $clog2(MAXB + 1);

  logic [2:0] bit_q;
  logic [6:0] sh_q;
  logic       byte_done;
  logic [7:0] byte_w;
  logic       room;

  assign byte_done = rise_i && (bit_q == 3'd7);
  assign byte_w    = {sh_q, mosi_i};
  assign room      = (count_o < CW'(MAXB));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= '0;
      sh_q    <= '0;
      count_o <= '0;
      bytes_o <= '0;
    end else if (start_i) begin
      bit_q   <= '0;
      count_o <= '0;
    end else if (rise_i) begin
      bit_q <= bit_q + 3'd1;
      sh_q  <= {sh_q[5:0], mosi_i};
      if (byte_done && room) begin
        bytes_o[count_o] <= byte_w;
        count_o          <= count_o + CW'(1);
      end
    end
  end

  // R4: the byte count never runs past the storage it indexes
  a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == CW'(MAXB)) |=> (count_o == CW'(MAXB)) || (count_o == '0));

endmodule

// File: rtl/spi_pg_tx.sv
module spi_pg_tx #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         fall_i,
  input  logic         sel_i,
  input  logic [W-1:0] snap_i,
  output logic         miso_o
);

  localparam int PW = $clog2(W + 1);

  logic [W-1:0]  snap_q;
  logic [PW-1:0] ptr_q;
  logic [W-1:0]  shifted;
  logic          bit_step;
  logic          bits_left;

  assign bits_left = (ptr_q < PW'(W));
  assign bit_step  = fall_i && sel_i && bits_left;
  assign shifted   = snap_q << ptr_q;
  assign miso_o    = bits_left ? shifted[W-1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      ptr_q  <= PW'(W);
    end else if (start_i) begin
      snap_q <= snap_i;
      ptr_q  <= '0;
    end else if (bit_step) begin
      ptr_q <= ptr_q + PW'(1);
    end
  end

  // R6: the captured value does not change inside a frame
  a_r6_snapshot_held: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(snap_q));

  // R7: the output bit moves only after a serial clock fall or a new frame
  a_r7_miso_moves_on_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_o != $past(miso_o)) |-> $past(fall_i || start_i));

endmodule

// File: rtl/spi_pg_decode.sv
module spi_pg_decode
  import spi_pg_pkg::*;
#(
  parameter int QTY_W  = 32,
  parameter int FREQ_W = 24,
  parameter int MAXB   = 13
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      end_i,
  input  logic [MAXB-1:0][7:0]      bytes_i,
  input  logic [$clog2(MAXB+1)-1:0] count_i,
  output logic                      axes_hit_o,
  output logic [QTY_W-1:0]          x_word_o,
  output logic                      load_o,
  output logic                      load_freq_o,
  output logic [QTY_W-1:0]          y_q,
  output logic [QTY_W-1:0]          z_q,
  output logic [FREQ_W-1:0]         freq_q
);

  localparam int CW      = $clog2(MAXB + 1);
  localparam int QB      = int'(bytes_for(QTY_W));
  localparam int FB      = int'(bytes_for(FREQ_W));
  localparam int AX_LEN  = int'(axes_frame_len(QTY_W));
  localparam int RT_LEN  = int'(rate_frame_len(FREQ_W));

  logic [QTY_W-1:0]  words [3];
  logic [FREQ_W-1:0] freq_word;
  logic              rate_hit;

  generate
    for (genvar a = 0; a < 3; a++) begin : g_axis
      always_comb begin
        words[a] = '0;
        for (int i = 0; i < QB; i++) begin
          words[a] = QTY_W'({words[a], bytes_i[1 + a * QB + i]});
        end
      end
    end
  endgenerate

  always_comb begin
    freq_word = '0;
    for (int i = 0; i < FB; i++) begin
      freq_word = FREQ_W'({freq_word, bytes_i[1 + i]});
    end
  end

  assign axes_hit_o = end_i && (bytes_i[0] == OP_AXES) && (count_i >= CW'(AX_LEN));
  assign rate_hit   = end_i && (bytes_i[0] == OP_RATE) && (count_i >= CW'(RT_LEN));
  assign x_word_o   = words[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_o      <= 1'b0;
      load_freq_o <= 1'b0;
      y_q         <= '0;
      z_q         <= '0;
      freq_q      <= '0;
    end else begin
      load_o      <= axes_hit_o;
      load_freq_o <= rate_hit;
      if (axes_hit_o) begin
        y_q <= words[1];
        z_q <= words[2];
      end
      if (rate_hit) begin
        freq_q <= freq_word;
      end
    end
  end

  // R2: the position strobe lasts a single cycle
  a_r2_axes_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);

  // R3: the rate strobe lasts a single cycle
  a_r3_rate_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    load_freq_o |=> !load_freq_o);

  // R4: strobes only follow a frame end
  a_r4_strobe_needs_end: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o || load_freq_o) |-> $past(end_i));

  // R4: held quantities change only with an accepted frame
  a_r4_axes_held: assert property (@(posedge clk) disable iff (!rst_n)
    !load_o |-> ($stable(y_q) && $stable(z_q)));

endmodule

// File: rtl/spi_pg_gen.sv
module spi_pg_gen #(
  parameter int QTY_W  = 32,
  parameter int FREQ_W = 24,
  parameter int ACC_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [QTY_W-1:0]  qty_i,
  input  logic [FREQ_W-1:0] freq_i,
  output logic              pulse_o,
  output logic [QTY_W-1:0]  rem_o
);

  function automatic logic [ACC_W:0] phase_step(input logic [ACC_W-1:0] acc,
                                                input logic [FREQ_W-1:0] f);
    return {1'b0, acc} + (ACC_W + 1)'(f);
  endfunction

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic             running;
  logic             carry;

  assign running = (freq_i != '0) && (rem_o != '0);
  assign sum     = phase_step(acc_q, freq_i);
  assign carry   = sum[ACC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      rem_o   <= '0;
      pulse_o <= 1'b0;
    end else if (load_i) begin
      acc_q   <= '0;
      rem_o   <= qty_i;
      pulse_o <= 1'b0;
    end else if (running) begin
      acc_q   <= sum[ACC_W-1:0];
      pulse_o <= carry;
      if (carry) rem_o <= rem_o - QTY_W'(1);
    end else begin
      pulse_o <= 1'b0;
    end
  end

  // R5: each pulse matches a one-step drop in the count
  a_r5_pulse_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> (rem_o == $past(rem_o) - QTY_W'(1)));

  // R5: a zero rate word yields no pulse
  a_r5_zero_rate_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_i == '0) |=> !pulse_o);

  // R5: an exhausted count yields no pulse
  a_r5_zero_count_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_o == '0 && !load_i) |=> !pulse_o);

  // R8: a load restarts the phase at zero
  a_r8_load_clears_phase: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (acc_q == '0 && !pulse_o));

endmodule

// File: rtl/spi_pulse_gen.sv
module spi_pulse_gen
  import spi_pg_pkg::*;
#(
  parameter int QTY_W       = 32,
  parameter int FREQ_W      = 24,
  parameter int ACC_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sck,
  input  logic             spi_mosi,
  input  logic             spi_cs_n,
  output logic             spi_miso,
  output logic             pulse_out,
  output logic             load_axes,
  output logic             load_rate,
  output logic [QTY_W-1:0] y_qty,
  output logic [QTY_W-1:0] z_qty
);

  localparam int MAXB = int'(axes_frame_len(QTY_W));
  localparam int CW   = $clog2(MAXB + 1);

  logic                sck_rise;
  logic                sck_fall;
  logic                mosi_s;
  logic                selected;
  logic                frame_start;
  logic                frame_end;
  logic                rx_rise;
  logic [MAXB-1:0][7:0] frame_bytes;
  logic [CW-1:0]       frame_count;
  logic                axes_hit;
  logic [QTY_W-1:0]    x_word;
  logic [FREQ_W-1:0]   freq_word;
  logic [QTY_W-1:0]    remaining;

  assign rx_rise = sck_rise & selected;

  spi_pg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .sck_pin     (spi_sck),
    .mosi_pin    (spi_mosi),
    .csn_pin     (spi_cs_n),
    .sck_rise    (sck_rise),
    .sck_fall    (sck_fall),
    .mosi_s      (mosi_s),
    .selected    (selected),
    .frame_start (frame_start),
    .frame_end   (frame_end)
  );

  spi_pg_rx #(.MAXB(MAXB)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (frame_start),
    .rise_i  (rx_rise),
    .mosi_i  (mosi_s),
    .bytes_o (frame_bytes),
    .count_o (frame_count)
  );

  spi_pg_decode #(.QTY_W(QTY_W), .FREQ_W(FREQ_W), .MAXB(MAXB)) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .end_i       (frame_end),
    .bytes_i     (frame_bytes),
    .count_i     (frame_count),
    .axes_hit_o  (axes_hit),
    .x_word_o    (x_word),
    .load_o      (load_axes),
    .load_freq_o (load_rate),
    .y_q         (y_qty),
    .z_q         (z_qty),
    .freq_q      (freq_word)
  );

  spi_pg_gen #(.QTY_W(QTY_W), .FREQ_W(FREQ_W), .ACC_W(ACC_W)) u_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (axes_hit),
    .qty_i   (x_word),
    .freq_i  (freq_word),
    .pulse_o (pulse_out),
    .rem_o   (remaining)
  );

  spi_pg_tx #(.W(QTY_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (frame_start),
    .fall_i  (sck_fall),
    .sel_i   (selected),
    .snap_i  (remaining),
    .miso_o  (spi_miso)
  );

  // R2: the position strobe follows the internal accept by one cycle
  a_r2_strobe_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $past(axes_hit) |-> load_axes);

endmodule

// File: tb/tb_spi_pulse_gen.sv
`timescale 1ns/1ps
module tb_spi_pulse_gen;

  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0;
  logic spi_mosi = 1'b0;
  logic spi_cs_n = 1'b1;
  logic spi_miso;
  logic pulse_out;
  logic load_axes;
  logic load_rate;
  logic [31:0] y_qty;
  logic [31:0] z_qty;

  always #2 clk = ~clk;

  spi_pulse_gen dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .pulse_out(pulse_out),
    .load_axes(load_axes), .load_rate(load_rate), .y_qty(y_qty), .z_qty(z_qty)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_rem = '0;
  logic [23:0] m_acc = '0;
  logic [23:0] m_freq = '0;
  logic [31:0] m_y = '0;
  logic [31:0] m_z = '0;
  logic [31:0] pend_x, pend_y, pend_z;
  logic [23:0] pend_f;
  logic [31:0] snap_exp = '0;
  int kind = 0;
  int cs_hi = 0;
  int cs_lo = 0;
  logic [7:0] txbuf [0:15];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [24:0] sum;
      logic exp_p;
      if (spi_cs_n) begin cs_hi++; cs_lo = 0; end
      else begin cs_lo++; cs_hi = 0; end
      if (load_axes) begin
        m_rem = pend_x; m_acc = '0; exp_p = 1'b0; m_y = pend_y; m_z = pend_z;
      end else begin
        if (m_freq != 0 && m_rem != 0) begin
          sum = {1'b0, m_acc} + {1'b0, m_freq};
          m_acc = sum[23:0];
          exp_p = sum[24];
          if (exp_p) m_rem = m_rem - 1;
        end else exp_p = 1'b0;
        if (load_rate) m_freq = pend_f;
      end
      chk(pulse_out == exp_p, "R5 pulse", {31'd0, pulse_out}, {31'd0, exp_p});
      chk(y_qty == m_y, "R2 y_qty", y_qty, m_y);
      chk(z_qty == m_z, "R2 z_qty", z_qty, m_z);
      if (cs_lo == 2) snap_exp = m_rem;
      if (cs_hi == 3) begin
        chk(load_axes == (kind == 1), "R2/R4 load_axes timing", {31'd0, load_axes}, {31'd0, kind == 1});
        chk(load_rate == (kind == 2), "R3/R4 load_rate timing", {31'd0, load_rate}, {31'd0, kind == 2});
        kind = 0;
      end else if (cs_hi != 3 && (load_axes || load_rate)) begin
        chk(1'b0, "R4 stray strobe", {30'd0, load_axes, load_rate}, 32'd0);
      end
    end
  end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one framed transaction; checks the readback (R6) and trailing zero bits (R7)
  task automatic xfer(input int n, input int k, input string tag);
    logic [31:0] rd = '0;
    int extra = 0;
    int nb = 0;
    @(negedge clk); #1 spi_cs_n = 1'b0;
    for (int b = 0; b < n; b++) begin
      for (int i = 7; i >= 0; i--) begin
        wait_clks(H); #1 spi_mosi = txbuf[b][i];
        if (nb < 32) rd = {rd[30:0], spi_miso};
        else if (spi_miso) extra++;
        nb++;
        wait_clks(2); #1 spi_sck = 1'b1;
        wait_clks(H); #1 spi_sck = 1'b0;
      end
    end
    wait_clks(H);
    kind = k;
    #1 spi_cs_n = 1'b1;
    wait_clks(H);
    if (n >= 4) chk(rd == snap_exp, {"R6 readback ", tag}, rd, snap_exp);
    if (n > 4) chk(extra == 0, {"R7 bits after 32 ", tag}, extra, 0);
  endtask

  task automatic send_axes(input logic [31:0] x, y, z);
    txbuf[0] = 8'h01;
    for (int i = 0; i < 4; i++) begin
      txbuf[1 + i] = x[31 - 8*i -: 8];
      txbuf[5 + i] = y[31 - 8*i -: 8];
      txbuf[9 + i] = z[31 - 8*i -: 8];
    end
    pend_x = x; pend_y = y; pend_z = z;
    xfer(13, 1, "axes");
  endtask

  task automatic send_rate(input logic [23:0] f);
    txbuf[0] = 8'h02; txbuf[1] = f[23:16]; txbuf[2] = f[15:8]; txbuf[3] = f[7:0];
    pend_f = f;
    xfer(4, 2, "rate");
  endtask

  task automatic readback(input string tag);
    for (int i = 0; i < 4; i++) txbuf[i] = 8'h00;
    xfer(4, 0, tag);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    wait_clks(5);
    #1 rst_n = 1'b1;
    wait_clks(2);
    // R1 reset state
    chk(spi_miso == 0 && pulse_out == 0, "R1 miso/pulse", {30'd0, spi_miso, pulse_out}, 0);
    chk(load_axes == 0 && load_rate == 0, "R1 strobes", {30'd0, load_axes, load_rate}, 0);
    chk(y_qty == 0 && z_qty == 0, "R1 quantities", y_qty | z_qty, 0);
    readback("R1 zero count");

    // R3 rate frame, no pulses while count is zero (R5)
    send_rate(24'h400000);
    // R2 position frame; R8 phase restarts
    send_axes(32'd200, 32'h12345678, 32'h00ABCDEF);
    wait_clks(300);
    readback("R6 mid countdown");
    chk(snap_exp < 200 && snap_exp > 0, "R6 count moving", snap_exp, 32'd100);

    // R4 short position frame ignored
    txbuf[0] = 8'h01; for (int i = 1; i < 6; i++) txbuf[i] = 8'hFF;
    xfer(6, 0, "R4 short");
    // R4 unknown command ignored
    txbuf[0] = 8'h07; for (int i = 1; i < 13; i++) txbuf[i] = 8'h5A;
    xfer(13, 0, "R4 unknown");
    chk(y_qty == 32'h12345678, "R4 y held", y_qty, 32'h12345678);

    // R3 rate change mid-count
    send_rate(24'h555555);
    for (int t = 0; t < 4000 && m_rem != 0; t++) wait_clks(1);
    wait_clks(10);
    readback("R5 count exhausted");
    chk(snap_exp == 0, "R5 reaches zero", snap_exp, 0);

    // R5 zero rate holds the count
    send_rate(24'h000000);
    send_axes(32'd50, 32'h0, 32'hFFFFFFFF);
    wait_clks(200);
    readback("R5 zero rate");
    chk(snap_exp == 50, "R5 zero rate keeps count", snap_exp, 50);

    // R8 reload with a fast rate, then reload mid-count
    send_rate(24'h800000);
    send_axes(32'h01020304, 32'hA5A5A5A5, 32'h3C3C3C3C);
    wait_clks(100);
    readback("R7 wide value");
    send_axes(32'd3, 32'd7, 32'd9);
    wait_clks(40);
    readback("R8 after reload");
    chk(snap_exp == 0, "R8 short count done", snap_exp, 0);
    wait_clks(20);
    finish_run();
  end

endmodule